// File: doc/BRIEF.md
# Four-Lane Double-Vote Decider

This block judges the results of four execution lanes once per step. Three lanes run distinct variants of one computation and the fourth runs a second copy of one of those variants. The decider forms two overlapping three-input votes, each built from the two independent results and one copy of the replicated variant. Because the two copies should always match, comparing the two votes does more than mask an error. It also points to the lane or the variant that most likely produced the error.

Each lane has a counter of consecutive suspicions. When one lane is suspected on enough steps in a row, the decider treats the fault as a persistent hardware fault and retires that lane. From then on it takes a plain two-of-three majority over the lanes that remain active, and it reports the retired lane so that external control can remap variants. Variant execution and the lane activation map come from outside.

Top module: `dvd_decider`

## Requirements
- R1: A step presented with `step_valid` high produces its decision on `dec_valid`, `dec_fail`, `dec_data`, `dec_class` and `suspect` on the next clock edge. These outputs are zero in every cycle that does not follow a step. Reset (low `rst_n`, synchronous) clears all outputs and any retirement.
- R2: `dup_sel` = d assigns the lane roles, with all indices taken modulo 4. Lane d is copy A and lane d+1 is copy B. Lanes d+2 and d+3 hold the two independent variants. Vote A uses copy A and both independent lanes. Vote B uses copy B and both independent lanes.
- R3: With all four lanes active and every result equal, the decider delivers that value with class 0 and no suspect bit set.
- R4: If vote B is unanimous and vote A is not, the decider delivers the independent value with class 1 and sets `suspect` bit d (copy A's lane).
- R5: If vote A is unanimous and vote B is not, the decider delivers the independent value with class 2 and sets `suspect` bit d+1 (copy B's lane).
- R6: If neither vote is unanimous but the two independent results agree, the replicated variant is judged faulty. The decider delivers the independent value with class 3 and no suspect bit.
- R7: If the two independent results differ, but the two copies agree with each other and with one independent result, the decider delivers the copies' value with class 4 and no suspect bit.
- R8: If no agreement described in R3 to R7 exists, nothing is delivered. `dec_fail` rises, `dec_class` is 7 and `dec_valid` stays low.
- R9: A lane suspected on THRESH consecutive four-lane steps (default 3) is retired. `retired_valid` rises and `retired_lane` gives its index. Any four-lane step that does not suspect a lane clears that lane's count.
- R10: A retirement holds until reset. No second lane is retired.
- R11: When exactly three lanes are effectively active (`act_map` minus the retired lane), the decider takes a 2-of-3 majority over them. It reports class 0 when all three agree, class 5 for a 2-of-3 agreement, and class 7 with `dec_fail` when all three differ. The excluded lane's value has no effect and no suspect bit is set.
- R12: With fewer than three effectively active lanes, every step fails with class 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Lane results valid this cycle |
| lane_res | input | 4*W | Lane results, lane i at bits [i*W +: W] |
| dup_sel | input | 2 | Index of copy A. Copy B is the next lane, modulo 4 |
| act_map | input | 4 | Lanes externally marked active |
| dec_valid | output | 1 | Decision delivered |
| dec_data | output | W | Delivered value |
| dec_fail | output | 1 | Detected failure, nothing delivered |
| dec_class | output | 3 | Fault classification code |
| suspect | output | 4 | One-hot lane suspected this step |
| retired_valid | output | 1 | A lane has been retired |
| retired_lane | output | 2 | Index of the retired lane |

## Verification
The hardest state to reach is retirement, because it needs an unbroken run of suspicions against one lane. The bench first sends two faulty steps on copy B's lane, then a clean step, then two more faulty steps. It checks that this pattern does not retire the lane, since the clean step resets the run. Only a third consecutive faulty step retires the lane. In that degraded state the bench puts a conflicting value on the retired lane to show that the majority ignores it. It also drops a lane from `act_map` to reach the fewer-than-three case.

// File: rtl/dvd_pkg.sv
`timescale 1ns/1ps
// Shared classification codes for the double-vote decider.
package dvd_pkg;
    typedef enum logic [2:0] {
        CLS_CLEAN  = 3'd0,
        CLS_SUSP_A = 3'd1,
        CLS_SUSP_B = 3'd2,
        CLS_DUP    = 3'd3,
        CLS_INDEP  = 3'd4,
        CLS_MAJ    = 3'd5,
        CLS_FAIL   = 3'd7
    } dvd_class_e;
endpackage

// File: rtl/dvd_vote_core.sv
`timescale 1ns/1ps
// Two overlapping three-input votes over four lanes.
// Assumes lane dup_sel_i and lane dup_sel_i+1 (mod 4) carry the same variant.
module dvd_vote_core import dvd_pkg::*; #(
    parameter int W = 8
) (
    input  logic [4*W-1:0] res_i,
    input  logic [1:0]     dup_sel_i,
    output logic           deliver_o,
    output logic [W-1:0]   data_o,
    output dvd_class_e     cls_o,
    output logic [3:0]     susp_o
);
    logic [1:0]   idx_a, idx_b, idx_n1, idx_n2;
    logic [W-1:0] cpy_a, cpy_b, ind_1, ind_2;
    logic         ind_eq, unan_a, unan_b;

    assign idx_a  = dup_sel_i;
    assign idx_b  = dup_sel_i + 2'd1;
    assign idx_n1 = dup_sel_i + 2'd2;
    assign idx_n2 = dup_sel_i + 2'd3;

    assign cpy_a = res_i[idx_a*W +: W];
    assign cpy_b = res_i[idx_b*W +: W];
    assign ind_1 = res_i[idx_n1*W +: W];
    assign ind_2 = res_i[idx_n2*W +: W];

    assign ind_eq = (ind_1 == ind_2);
    assign unan_a = ind_eq && (cpy_a == ind_1);
    assign unan_b = ind_eq && (cpy_b == ind_1);

    // Classify the step from the agreement pattern of the two votes.
    always_comb begin
        deliver_o = 1'b1;
        data_o    = ind_1;
        cls_o     = CLS_CLEAN;
        susp_o    = '0;
        if (unan_a && unan_b) begin
            cls_o = CLS_CLEAN;
        end else if (unan_b) begin
            cls_o         = CLS_SUSP_A;
            susp_o[idx_a] = 1'b1;
        end else if (unan_a) begin
            cls_o         = CLS_SUSP_B;
            susp_o[idx_b] = 1'b1;
        end else if (ind_eq) begin
            cls_o = CLS_DUP;
        end else if ((cpy_a == cpy_b) && ((cpy_a == ind_1) || (cpy_a == ind_2))) begin
            cls_o  = CLS_INDEP;
            data_o = cpy_a;
        end else begin
            deliver_o = 1'b0;
            cls_o     = CLS_FAIL;
        end
    end
endmodule

// File: rtl/dvd_major3.sv
`timescale 1ns/1ps
// Plain 2-of-3 majority over the three lanes set in act_i.
// Assumes exactly one bit of act_i is clear whenever the result is used.
module dvd_major3 import dvd_pkg::*; #(
    parameter int W = 8
) (
    input  logic [4*W-1:0] res_i,
    input  logic [3:0]     act_i,
    output logic           deliver_o,
    output logic [W-1:0]   data_o,
    output dvd_class_e     cls_o
);
    logic [1:0]   gap;
    logic [1:0]   la, lb, lc;
    logic [W-1:0] va, vb, vc;

    // Locate the lane left out of the vote.
    always_comb begin
        gap = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (!act_i[i]) gap = 2'(i);
        end
    end

    assign la = gap + 2'd1;
    assign lb = gap + 2'd2;
    assign lc = gap + 2'd3;
    assign va = res_i[la*W +: W];
    assign vb = res_i[lb*W +: W];
    assign vc = res_i[lc*W +: W];

    // Pick the majority value among the three remaining lanes.
    always_comb begin
        deliver_o = 1'b1;
        data_o    = va;
        cls_o     = CLS_MAJ;
        if ((va == vb) && (vb == vc)) begin
            cls_o = CLS_CLEAN;
        end else if ((va == vb) || (va == vc)) begin
            data_o = va;
        end else if (vb == vc) begin
            data_o = vb;
        end else begin
            deliver_o = 1'b0;
            cls_o     = CLS_FAIL;
        end
    end
endmodule

// File: rtl/dvd_health.sv
`timescale 1ns/1ps
// Per-lane consecutive-suspicion counters and one-shot lane retirement.
// Assumes susp_i is one-hot or zero and is only meaningful when step_i is high.
module dvd_health #(
    parameter int THRESH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic [3:0] susp_i,
    output logic       ret_valid_o,
    output logic [1:0] ret_lane_o
);
    localparam int             CW = (THRESH < 2) ? 1 : $clog2(THRESH + 1);
    localparam logic [CW-1:0]  TH = CW'(THRESH);

    logic [CW-1:0] cnt_q [4];
    logic [3:0]    hit;
    logic [1:0]    hit_lane;
    logic          ret_q;
    logic [1:0]    lane_q;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign hit[g] = susp_i[g] && (CW'(cnt_q[g] + 1'b1) == TH);

        // Count consecutive suspected steps, clear on any unsuspected step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (step_i && !ret_q) begin
                if (!susp_i[g])         cnt_q[g] <= '0;
                else if (cnt_q[g] != TH) cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= TH); // R9
    end

    // Encode the lane that reached the threshold.
    always_comb begin
        hit_lane = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (hit[i]) hit_lane = 2'(i);
        end
    end

    // Latch the first retirement until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q  <= 1'b0;
            lane_q <= 2'd0;
        end else if (step_i && !ret_q && (|hit)) begin
            ret_q  <= 1'b1;
            lane_q <= hit_lane;
        end
    end

    assign ret_valid_o = ret_q;
    assign ret_lane_o  = lane_q;

    AST_RETIRE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_q) |-> $past(step_i)); // R9
endmodule

// File: rtl/dvd_decider.sv
`timescale 1ns/1ps
// Four-lane decider: double vote while all lanes are active, plain majority
// over three lanes otherwise, failure below three. Outputs are registered.
// Assumes act_map and dup_sel are stable for the step they accompany.
module dvd_decider import dvd_pkg::*; #(
    parameter int W      = 8,
    parameter int THRESH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_valid,
    input  logic [4*W-1:0] lane_res,
    input  logic [1:0]     dup_sel,
    input  logic [3:0]     act_map,
    output logic           dec_valid,
    output logic [W-1:0]   dec_data,
    output logic           dec_fail,
    output logic [2:0]     dec_class,
    output logic [3:0]     suspect,
    output logic           retired_valid,
    output logic [1:0]     retired_lane
);
    logic           dv_del, mj_del, sel_del;
    logic [W-1:0]   dv_data, mj_data, sel_data;
    dvd_class_e     dv_cls, mj_cls, sel_cls;
    logic [3:0]     dv_susp, sel_susp;
    logic [3:0]     ret_mask, eff;
    logic           mode_dbl, mode_tri;

    dvd_vote_core #(.W(W)) vote_i (
        .res_i(lane_res), .dup_sel_i(dup_sel),
        .deliver_o(dv_del), .data_o(dv_data), .cls_o(dv_cls), .susp_o(dv_susp)
    );

    dvd_major3 #(.W(W)) maj_i (
        .res_i(lane_res), .act_i(eff),
        .deliver_o(mj_del), .data_o(mj_data), .cls_o(mj_cls)
    );

    dvd_health #(.THRESH(THRESH)) health_i (
        .clk(clk), .rst_n(rst_n),
        .step_i(step_valid && mode_dbl), .susp_i(sel_susp),
        .ret_valid_o(retired_valid), .ret_lane_o(retired_lane)
    );

    assign ret_mask = retired_valid ? (4'b0001 << retired_lane) : 4'b0000;
    assign eff      = act_map & ~ret_mask;
    assign mode_dbl = (eff == 4'hF);
    assign mode_tri = ($countones(eff) == 3);

    // Choose the decision source from the number of effective lanes.
    always_comb begin
        sel_susp = '0;
        if (mode_dbl) begin
            sel_del  = dv_del;
            sel_data = dv_data;
            sel_cls  = dv_cls;
            sel_susp = dv_susp;
        end else if (mode_tri) begin
            sel_del  = mj_del;
            sel_data = mj_data;
            sel_cls  = mj_cls;
        end else begin
            sel_del  = 1'b0;
            sel_data = '0;
            sel_cls  = CLS_FAIL;
        end
    end

    // Register the decision one cycle after the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_fail  <= 1'b0;
            dec_data  <= '0;
            dec_class <= 3'd0;
            suspect   <= '0;
        end else begin
            dec_valid <= step_valid && sel_del;
            dec_fail  <= step_valid && !sel_del;
            dec_data  <= (step_valid && sel_del) ? sel_data : '0;
            dec_class <= step_valid ? 3'(sel_cls) : 3'd0;
            suspect   <= step_valid ? sel_susp : 4'd0;
        end
    end

    AST_OUT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid || dec_fail) |-> $past(step_valid)); // R1
    AST_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_fail)); // R8
    AST_SUSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(suspect)); // R4
    AST_SUSP_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (|suspect) |-> dec_valid); // R5
    AST_RETIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        retired_valid |=> (retired_valid && $stable(retired_lane))); // R10
endmodule

// File: tb/dvd_decider_tb_top.sv
`timescale 1ns/1ps
module dvd_decider_tb_top;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_valid = 1'b0;
    logic [4*W-1:0] lane_res = '0;
    logic [1:0]    dup_sel = 2'd0;
    logic [3:0]    act_map = 4'hF;
    logic          dec_valid, dec_fail, retired_valid;
    logic [W-1:0]  dec_data;
    logic [2:0]    dec_class;
    logic [3:0]    suspect;
    logic [1:0]    retired_lane;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dvd_decider #(.W(W), .THRESH(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .lane_res(lane_res),
        .dup_sel(dup_sel), .act_map(act_map), .dec_valid(dec_valid),
        .dec_data(dec_data), .dec_fail(dec_fail), .dec_class(dec_class),
        .suspect(suspect), .retired_valid(retired_valid), .retired_lane(retired_lane)
    );

    // {lane results, dup_sel, valid, data, class, suspect}
    localparam logic [49:0] VEC [10] = '{
        {32'h05050505, 2'd0, 1'b1, 8'h05, 3'd0, 4'b0000},  // R3
        {32'h05050509, 2'd0, 1'b1, 8'h05, 3'd1, 4'b0001},  // R4
        {32'h05050905, 2'd0, 1'b1, 8'h05, 3'd2, 4'b0010},  // R5
        {32'h05050909, 2'd0, 1'b1, 8'h05, 3'd3, 4'b0000},  // R6
        {32'h05070505, 2'd0, 1'b1, 8'h05, 3'd4, 4'b0000},  // R7
        {32'h04030201, 2'd0, 1'b0, 8'h00, 3'd7, 4'b0000},  // R8
        {32'h04080404, 2'd2, 1'b1, 8'h04, 3'd1, 4'b0100},  // R2 R4
        {32'h03030306, 2'd3, 1'b1, 8'h03, 3'd2, 4'b0001},  // R2 R5
        {32'h11111122, 2'd1, 1'b1, 8'h11, 3'd4, 4'b0000},  // R2 R7
        {32'h03020103, 2'd1, 1'b1, 8'h03, 3'd3, 4'b0000}   // R2 R6
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one step, then sample the registered decision at the next negedge.
    task automatic step(input logic [31:0] res, input logic [1:0] d, input logic [3:0] act);
        @(negedge clk);
        lane_res   = res;
        dup_sel    = d;
        act_map    = act;
        step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic expect_dec(input string req, input logic v, input logic [7:0] dat,
                              input logic [2:0] cls, input logic [3:0] sus);
        chk(dec_valid == v, req, dec_valid, v);
        chk(dec_fail == !v, req, dec_fail, !v);
        chk(dec_class == cls, req, dec_class, cls);
        chk(suspect == sus, req, suspect, sus);
        if (v) chk(dec_data == dat, req, dec_data, dat);
    endtask

    initial begin
        #2000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dec_valid == 0 && dec_fail == 0 && suspect == 0, "R1", dec_valid, 0);
        chk(retired_valid == 0, "R1", retired_valid, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            step(VEC[i][49:18], VEC[i][17:16], 4'hF);
            expect_dec("R2-table", VEC[i][15], VEC[i][14:7], VEC[i][6:4], VEC[i][3:0]);
        end

        // R1: no step, quiet outputs
        @(negedge clk);
        chk(dec_valid == 0 && dec_fail == 0 && dec_class == 0, "R1", dec_valid, 0);

        // R9: interrupted run on lane 1 does not retire
        step(32'h05050905, 2'd0, 4'hF);
        step(32'h05050905, 2'd0, 4'hF);
        step(32'h05050505, 2'd0, 4'hF);
        step(32'h05050905, 2'd0, 4'hF);
        step(32'h05050905, 2'd0, 4'hF);
        chk(retired_valid == 0, "R9", retired_valid, 0);
        step(32'h05050905, 2'd0, 4'hF);
        expect_dec("R5", 1'b1, 8'h05, 3'd2, 4'b0010);
        chk(retired_valid == 1, "R9", retired_valid, 1);
        chk(retired_lane == 2'd1, "R9", retired_lane, 1);

        // R11: majority over lanes 0,2,3
        step(32'h06059905, 2'd0, 4'hF);
        expect_dec("R11", 1'b1, 8'h05, 3'd5, 4'b0000);
        step(32'h07070007, 2'd0, 4'hF);
        expect_dec("R11", 1'b1, 8'h07, 3'd0, 4'b0000);
        step(32'h03020901, 2'd0, 4'hF);
        expect_dec("R11", 1'b0, 8'h00, 3'd7, 4'b0000);

        // R10: faults on another lane cannot retire it
        step(32'h05050509, 2'd0, 4'hF);
        step(32'h05050509, 2'd0, 4'hF);
        step(32'h05050509, 2'd0, 4'hF);
        chk(retired_valid == 1 && retired_lane == 2'd1, "R10", retired_lane, 1);

        // R12: fewer than three effective lanes
        step(32'h05050505, 2'd0, 4'b0011);
        expect_dec("R12", 1'b0, 8'h00, 3'd7, 4'b0000);

        // R1: reset clears retirement, double vote returns
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(retired_valid == 0, "R1", retired_valid, 0);
        step(32'h05050509, 2'd0, 4'hF);
        expect_dec("R4", 1'b1, 8'h05, 3'd1, 4'b0001);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule